// File: doc/BRIEF.md
# Indexed Redirection-Table Register Window

This block is the bus-facing front-end of an interrupt routing controller. It exposes two 32-bit registers on a small memory-mapped bus. The first selects an internal index. The second is a data window that reads or writes whatever register that index names. The internal space holds an identity register, a read-only version word, an arbitration word, and one 64-bit redirection entry per interrupt pin, split into a low word and a high word.

The low word of an entry carries the vector, the polarity, the trigger mode and the mask. It also carries two status bits that software cannot change. A legacy wire-routing mode follows the mask bit of pin 0. An unmask of pin 0 that the current routing mode does not allow discards the entire entry write.

Every committed entry write re-checks its pin against the pin's input level. If the pin should fire, the block issues a delivery request. A level-triggered delivery marks the entry as waiting for acknowledge.

Top module: `regwin_frontend`

## Requirements
- R1: Every request receives a response, with `rsp_valid` high, exactly one clock cycle later. No response appears without a request.
- R2: Only accesses with `req_size` equal to 4 (bytes) are accepted. Any other size returns `rsp_err`=1 with `rsp_rdata`=0 and changes no state.
- R3: Offset 0x00 is the select register. A write stores only data bits 7:0, and a read returns the stored byte zero-extended. A read at any offset other than 0x00 and 0x10 returns 0xFFFFFFFF. A write at any such offset has no effect.
- R4: Through the window, index 0x00 writes the identity from data bits 27:24. Indices 0x00 and 0x02 both read the identity in bits 27:24. Index 0x01 reads ((NUM_PINS-1) << 16) | 0x11. Writes to indices 0x01 and 0x02 are ignored.
- R5: Pin p's low word is at index 0x10+2p and its high word at 0x10+2p+1. A high-word write stores all 32 bits. Indices at or beyond 0x10+2*NUM_PINS read 0 and ignore writes.
- R6: A low-word write takes every bit from the write data except bit 12 (delivery status) and bit 14 (remote IRR), which keep their stored values.
- R7: If a written entry has bit 15 (trigger: 1 = level, 0 = edge) equal to 0, its bit 14 is stored as 0.
- R8: `wire_mode` is encoded as 0 = none, 1 = legacy, 2 = controller.
  - A write that clears pin 0's mask bit (bit 16) from none or from legacy moves the mode to controller.
  - A write that sets that mask bit while in controller moves the mode to legacy.
  - A cycle with `ext_wire_we` high loads `ext_wire_mode` (values 0 to 2), and this load takes priority.
  - Nothing else changes the mode.
- R9: A write that clears pin 0's mask bit while the mode is controller is rejected. Neither the entry nor the mode changes.
- R10: A committed entry write issues a delivery request when all of the following hold:
  - the entry has mask bit 16 = 0;
  - bit 14 = 0;
  - `pin_level[p]` XOR bit 13 (polarity: 1 = active low) is 1.
  The request appears as `dlv_valid`=1 with `dlv_pin`=p and `dlv_vector` = bits 7:0, in the cycle of the response. A level-triggered delivery stores bit 14 = 1.
- R11: After reset, the select register and the identity are 0 and `wire_mode` is none. Every entry's low word is 0x00010000 and its high word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset within the block |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Size error |
| rsp_rdata | output | 32 | Read data |
| pin_level | input | NUM_PINS | Current level of each interrupt pin |
| ext_wire_we | input | 1 | Legacy side loads the wire mode |
| ext_wire_mode | input | 2 | Mode loaded by the legacy side |
| wire_mode | output | 2 | Current wire-routing mode |
| dlv_valid | output | 1 | Delivery request strobe |
| dlv_pin | output | $clog2(NUM_PINS) | Pin being delivered |
| dlv_vector | output | 8 | Vector of the delivered entry |

## Verification
The hardest case to reach is the rejected unmask of pin 0. Through the bus alone, the mode can only be controller while pin 0 is unmasked. The stimulus therefore masks pin 0 first, which drops the mode to legacy. It then uses the legacy-side load to force controller before the unmask write.

The preserved remote IRR bit is also only reachable indirectly. The stimulus first commits a level-triggered, unmasked entry whose pin is asserted. That sets the bit. Later writes then try to clear the bit, and an edge-trigger write removes it.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
   localparam int B_DSTAT = 12;
   localparam int B_POL   = 13;
   localparam int B_RIRR  = 14;
   localparam int B_TRIG  = 15;
   localparam int B_MASK  = 16;
   localparam logic [31:0] RO_BITS  = (32'd1 << B_DSTAT) | (32'd1 << B_RIRR);
   localparam logic [31:0] LO_RESET = 32'd1 << B_MASK;

   localparam logic [7:0] IDX_ID   = 8'h00;
   localparam logic [7:0] IDX_VER  = 8'h01;
   localparam logic [7:0] IDX_ARB  = 8'h02;
   localparam logic [7:0] IDX_TBL  = 8'h10;
   localparam logic [7:0] VER_CODE = 8'h11;
   localparam int ID_LSB  = 24;
   localparam int MAX_LSB = 16;

   typedef enum logic [1:0] {
      WM_NONE   = 2'd0,
      WM_LEGACY = 2'd1,
      WM_CTRL   = 2'd2
   } wire_mode_e;
endpackage

// File: rtl/regwin_entry_merge.sv
module regwin_entry_merge
   import regwin_pkg::*;
(
   input  logic [31:0] old_lo,
   input  logic [31:0] old_hi,
   input  logic [31:0] wdata,
   input  logic        hi_sel,
   output logic [31:0] new_lo,
   output logic [31:0] new_hi,
   output logic        mask_changed
);
   logic [31:0] merged;

   always_comb begin
      merged = (old_lo & RO_BITS) | (wdata & ~RO_BITS);
      new_lo = hi_sel ? old_lo : merged;
      if (!new_lo[B_TRIG]) new_lo[B_RIRR] = 1'b0;
      new_hi = hi_sel ? wdata : old_hi;
      mask_changed = old_lo[B_MASK] ^ new_lo[B_MASK];
   end
endmodule

// File: rtl/regwin_wire_fsm.sv
module regwin_wire_fsm
   import regwin_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       chg_valid,
   input  logic       was_masked,
   input  logic       ext_we,
   input  logic [1:0] ext_mode,
   output wire_mode_e mode,
   output logic       accept
);
   wire_mode_e mode_q;

   assign mode   = mode_q;
   assign accept = !(chg_valid && was_masked && mode_q == WM_CTRL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= WM_NONE;
      end else if (ext_we && ext_mode != 2'd3) begin
         mode_q <= wire_mode_e'(ext_mode);
      end else if (chg_valid && accept) begin
         if (was_masked)            mode_q <= WM_CTRL;
         else if (mode_q == WM_CTRL) mode_q <= WM_LEGACY;
      end
   end
endmodule

// File: rtl/regwin_read_mux.sv
module regwin_read_mux
   import regwin_pkg::*;
#(
   parameter int NUM_PINS = 24,
   parameter int ID_W     = 4
) (
   input  logic [7:0]      idx,
   input  logic [ID_W-1:0] id,
   input  logic [31:0]     lo_q [NUM_PINS],
   input  logic [31:0]     hi_q [NUM_PINS],
   output logic [31:0]     rdata
);
   localparam int PIN_W = $clog2(NUM_PINS);
   localparam logic [8:0] TBL_END = 9'(IDX_TBL) + 9'(2 * NUM_PINS);

   logic [7:0]       off;
   logic             hit;
   logic [PIN_W-1:0] pin;
   logic [31:0]      id_word;

   always_comb begin
      off     = (idx - IDX_TBL) >> 1;
      hit     = (idx >= IDX_TBL) && ({1'b0, idx} < TBL_END);
      pin     = hit ? PIN_W'(off) : '0;
      id_word = 32'(id) << ID_LSB;
      rdata   = '0;
      if (idx == IDX_ID || idx == IDX_ARB) rdata = id_word;
      else if (idx == IDX_VER)
         rdata = (32'(NUM_PINS - 1) << MAX_LSB) | 32'(VER_CODE);
      else if (hit) rdata = idx[0] ? hi_q[pin] : lo_q[pin];
   end
endmodule

// File: rtl/regwin_frontend.sv
module regwin_frontend
   import regwin_pkg::*;
#(
   parameter int NUM_PINS = 24,
   parameter int ID_W     = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   input  logic                        req_write,
   input  logic [7:0]                  req_addr,
   input  logic [2:0]                  req_size,
   input  logic [31:0]                 req_wdata,
   output logic                        rsp_valid,
   output logic                        rsp_err,
   output logic [31:0]                 rsp_rdata,
   input  logic [NUM_PINS-1:0]         pin_level,
   input  logic                        ext_wire_we,
   input  logic [1:0]                  ext_wire_mode,
   output logic [1:0]                  wire_mode,
   output logic                        dlv_valid,
   output logic [$clog2(NUM_PINS)-1:0] dlv_pin,
   output logic [7:0]                  dlv_vector
);
   localparam int PIN_W = $clog2(NUM_PINS);
   localparam logic [7:0] OFF_SEL = 8'h00;
   localparam logic [7:0] OFF_WIN = 8'h10;
   localparam logic [8:0] TBL_END = 9'(IDX_TBL) + 9'(2 * NUM_PINS);

   if (NUM_PINS < 2 || NUM_PINS > 120) begin : g_bad_pins
      $error("NUM_PINS must lie in 2..120");
   end
   if (ID_W < 1 || ID_W > 8) begin : g_bad_id
      $error("ID_W must lie in 1..8");
   end

   logic [7:0]       sel_q;
   logic [ID_W-1:0]  id_q;
   logic [31:0]      lo_q [NUM_PINS];
   logic [31:0]      hi_q [NUM_PINS];

   logic             acc, at_sel, at_win, tbl_hit, ent_wr, commit, fire;
   logic [7:0]       pin_full;
   logic [PIN_W-1:0] pin_idx;
   logic [31:0]      old_lo, old_hi, new_lo, new_hi, lo_commit, win_rd;
   logic             mask_changed, chg_valid, accept, asserted;
   wire_mode_e       mode;

   always_comb begin
      acc      = req_valid && (req_size == 3'd4);
      at_sel   = req_addr == OFF_SEL;
      at_win   = req_addr == OFF_WIN;
      tbl_hit  = (sel_q >= IDX_TBL) && ({1'b0, sel_q} < TBL_END);
      pin_full = (sel_q - IDX_TBL) >> 1;
      pin_idx  = tbl_hit ? PIN_W'(pin_full) : '0;
      old_lo   = lo_q[pin_idx];
      old_hi   = hi_q[pin_idx];
      ent_wr   = acc && req_write && at_win && tbl_hit;
   end

   regwin_entry_merge u_merge (
      .old_lo(old_lo), .old_hi(old_hi), .wdata(req_wdata), .hi_sel(sel_q[0]),
      .new_lo(new_lo), .new_hi(new_hi), .mask_changed(mask_changed)
   );

   assign chg_valid = ent_wr && (pin_idx == '0) && mask_changed;

   regwin_wire_fsm u_wire (
      .clk(clk), .rst_n(rst_n), .chg_valid(chg_valid),
      .was_masked(old_lo[B_MASK]), .ext_we(ext_wire_we),
      .ext_mode(ext_wire_mode), .mode(mode), .accept(accept)
   );
   assign wire_mode = mode;

   always_comb begin
      commit    = ent_wr && accept;
      asserted  = pin_level[pin_idx] ^ new_lo[B_POL];
      fire      = commit && !new_lo[B_MASK] && !new_lo[B_RIRR] && asserted;
      lo_commit = new_lo;
      if (fire && new_lo[B_TRIG]) lo_commit[B_RIRR] = 1'b1;
   end

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lo_q[g] <= LO_RESET;
            hi_q[g] <= '0;
         end else if (commit && pin_idx == PIN_W'(g)) begin
            lo_q[g] <= lo_commit;
            hi_q[g] <= new_hi;
         end
      end
   end

   regwin_read_mux #(.NUM_PINS(NUM_PINS), .ID_W(ID_W)) u_rd (
      .idx(sel_q), .id(id_q), .lo_q(lo_q), .hi_q(hi_q), .rdata(win_rd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q      <= '0;
         id_q       <= '0;
         rsp_valid  <= 1'b0;
         rsp_err    <= 1'b0;
         rsp_rdata  <= '0;
         dlv_valid  <= 1'b0;
         dlv_pin    <= '0;
         dlv_vector <= '0;
      end else begin
         if (acc && req_write && at_sel) sel_q <= req_wdata[7:0];
         if (acc && req_write && at_win && sel_q == IDX_ID)
            id_q <= req_wdata[ID_LSB +: ID_W];
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && !acc;
         if (acc && !req_write)
            rsp_rdata <= at_sel ? {24'd0, sel_q} : (at_win ? win_rd : 32'hFFFF_FFFF);
         else
            rsp_rdata <= '0;
         dlv_valid  <= fire;
         dlv_pin    <= pin_idx;
         dlv_vector <= new_lo[7:0];
      end
   end
endmodule

// File: rtl/regwin_checker.sv
module regwin_checker #(
   parameter int NUM_PINS = 24
) (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_write,
   input logic [7:0]  req_addr,
   input logic [2:0]  req_size,
   input logic        rsp_valid,
   input logic        rsp_err,
   input logic [31:0] rsp_rdata,
   input logic        ext_wire_we,
   input logic [1:0]  wire_mode,
   input logic        dlv_valid
);
   // R1
   a_r1_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   // R1
   a_r1_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R2
   a_r2_size_err: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size != 3'd4) |=> (rsp_err && rsp_rdata == 32'd0));
   // R3
   a_r3_dead_offset: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_size == 3'd4 &&
       req_addr != 8'h00 && req_addr != 8'h10) |=> rsp_rdata == 32'hFFFF_FFFF);
   // R8
   a_r8_wire_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!(req_valid && req_write) && !ext_wire_we) |=> $stable(wire_mode));
   // R8
   a_r8_wire_legal: assert property (@(posedge clk) disable iff (!rst_n)
      wire_mode != 2'd3);
   // R10
   a_r10_dlv_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_write) |=> !dlv_valid);
endmodule

bind regwin_frontend regwin_checker #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
   .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .ext_wire_we(ext_wire_we),
   .wire_mode(wire_mode), .dlv_valid(dlv_valid)
);

// File: tb/tb_regwin_frontend.sv
module tb_regwin_frontend;
   localparam int NP = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [2:0]  req_size = 3'd4;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;
   logic [NP-1:0] pin_level = '0;
   logic        ext_wire_we = 1'b0;
   logic [1:0]  ext_wire_mode = '0;
   logic [1:0]  wire_mode;
   logic        dlv_valid;
   logic [4:0]  dlv_pin;
   logic [7:0]  dlv_vector;

   int n_chk = 0, n_err = 0;
   logic [31:0] l_rd;
   logic        l_err, l_dv, l_rv;
   logic [4:0]  l_dp;
   logic [7:0]  l_vec;

   always #2.5 clk = ~clk;

   regwin_frontend #(.NUM_PINS(NP), .ID_W(4)) dut (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic wr, input logic [7:0] addr,
                       input logic [31:0] wd, input logic [2:0] sz);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = addr;
      req_wdata = wd; req_size = sz;
      @(negedge clk);
      req_valid = 1'b0;
      l_rv = rsp_valid; l_rd = rsp_rdata; l_err = rsp_err;
      l_dv = dlv_valid; l_dp = dlv_pin; l_vec = dlv_vector;
   endtask

   task automatic win_wr(input logic [7:0] idx, input logic [31:0] d);
      xfer(1'b1, 8'h00, {24'd0, idx}, 3'd4);
      xfer(1'b1, 8'h10, d, 3'd4);
   endtask

   task automatic win_rd(input logic [7:0] idx);
      xfer(1'b1, 8'h00, {24'd0, idx}, 3'd4);
      xfer(1'b0, 8'h10, 32'd0, 3'd4);
   endtask

   task automatic t_reset;
      xfer(1'b0, 8'h00, 0, 3'd4);
      check("R1 rsp_valid", {31'd0, l_rv}, 1);
      check("R11 select reset", l_rd, 0);
      check("R11 wire reset", {30'd0, wire_mode}, 0);
      win_rd(8'h00);
      check("R11 id reset", l_rd, 0);
      win_rd(8'h10);
      check("R11 entry lo reset", l_rd, 32'h0001_0000);
      win_rd(8'h11);
      check("R11 entry hi reset", l_rd, 0);
   endtask

   task automatic t_select;
      xfer(1'b1, 8'h00, 32'h1234_5601, 3'd4);
      xfer(1'b0, 8'h00, 0, 3'd4);
      check("R3 select low byte", l_rd, 32'h01);
      xfer(1'b1, 8'h00, 32'h77, 3'd2);
      check("R2 size error", {31'd0, l_err}, 1);
      xfer(1'b0, 8'h00, 0, 3'd2);
      check("R2 size read data", l_rd, 0);
      xfer(1'b0, 8'h00, 0, 3'd4);
      check("R2 select unchanged", l_rd, 32'h01);
      xfer(1'b1, 8'h08, 32'h55, 3'd4);
      xfer(1'b0, 8'h08, 0, 3'd4);
      check("R3 dead offset", l_rd, 32'hFFFF_FFFF);
      xfer(1'b0, 8'h00, 0, 3'd4);
      check("R3 dead write no effect", l_rd, 32'h01);
   endtask

   task automatic t_regs;
      win_wr(8'h00, 32'hFA00_0000);
      win_rd(8'h00);
      check("R4 id", l_rd, 32'h0A00_0000);
      win_rd(8'h02);
      check("R4 arb", l_rd, 32'h0A00_0000);
      win_wr(8'h01, 32'hFFFF_FFFF);
      win_wr(8'h02, 32'h0300_0000);
      win_rd(8'h01);
      check("R4 version", l_rd, 32'h0017_0011);
      win_rd(8'h00);
      check("R4 ro writes ignored", l_rd, 32'h0A00_0000);
   endtask

   task automatic t_entries;
      win_wr(8'h3F, 32'hAB00_00CD);
      win_rd(8'h3F);
      check("R5 last hi word", l_rd, 32'hAB00_00CD);
      win_wr(8'h40, 32'h1234_5678);
      win_rd(8'h40);
      check("R5 beyond table", l_rd, 0);
      win_rd(8'h3E);
      check("R5 last lo intact", l_rd, 32'h0001_0000);
   endtask

   task automatic t_irr;
      pin_level[3] = 1'b1;
      win_wr(8'h16, 32'h0000_8045);
      check("R10 level dlv", {31'd0, l_dv}, 1);
      check("R10 dlv pin", {27'd0, l_dp}, 3);
      check("R10 dlv vector", {24'd0, l_vec}, 32'h45);
      win_rd(8'h16);
      check("R10 irr set", l_rd, 32'h0000_C045);
      win_wr(8'h16, 32'h0000_9045);
      check("R10 no dlv while irr", {31'd0, l_dv}, 0);
      win_rd(8'h16);
      check("R6 status bits kept", l_rd, 32'h0000_C045);
      win_wr(8'h16, 32'h0000_0045);
      check("R7 edge dlv", {31'd0, l_dv}, 1);
      win_rd(8'h16);
      check("R7 irr cleared", l_rd, 32'h0000_0045);
      win_wr(8'h1A, 32'h0000_2050);
      check("R10 active low dlv", {31'd0, l_dv}, 1);
      check("R10 active low vector", {24'd0, l_vec}, 32'h50);
      win_wr(8'h1A, 32'h0001_2051);
      check("R10 masked no dlv", {31'd0, l_dv}, 0);
   endtask

   task automatic t_wire;
      win_wr(8'h10, 32'h0000_0020);
      check("R8 none to ctrl", {30'd0, wire_mode}, 2);
      check("R10 pin0 not asserted", {31'd0, l_dv}, 0);
      win_wr(8'h10, 32'h0001_0020);
      check("R8 ctrl to legacy", {30'd0, wire_mode}, 1);
      win_wr(8'h10, 32'h0000_0021);
      check("R8 legacy to ctrl", {30'd0, wire_mode}, 2);
      win_wr(8'h10, 32'h0001_0021);
      check("R8 mask again", {30'd0, wire_mode}, 1);
      @(negedge clk); ext_wire_we = 1'b1; ext_wire_mode = 2'd2;
      @(negedge clk); ext_wire_we = 1'b0;
      check("R8 external load", {30'd0, wire_mode}, 2);
      win_wr(8'h10, 32'h0000_0030);
      check("R9 mode kept", {30'd0, wire_mode}, 2);
      win_rd(8'h10);
      check("R9 entry kept", l_rd, 32'h0001_0021);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_select();
      t_regs();
      t_entries();
      t_irr();
      t_wire();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule